// File: doc/BRIEF.md
# Configurable Mesh Functional Unit Cell

This block is one processing cell meant to be tiled into a mesh of functional units that work on 16-bit operands. Every cycle it can accept a pair of operands, a left one and a right one, together with a valid bit. The left operand may be shifted or rotated on its way in. The right operand always arrives unchanged. The two are then combined bitwise through a programmable four-entry truth table. In parallel, a separate adder of the raw operands produces the zero, negative and carry-out condition flags. An output selector picks the word that the cell drives out.

A single configuration word holds every setting of the cell: the shift amount and kind, the truth table, the output choice and an extra delay of zero to three cycles. The extra delay lets a designer line up results that reach a later cell over paths of different length. The configuration is loaded through a plain write strobe. Each result travels with its valid bit, so a downstream cell can tell real results apart from idle cycles.

Top module: `mesh_fu_cell`

## Requirements
- R1: After reset, outValid is 0, outData is 0 and all three flags are 0. The configuration word resets to all zeros.
- R2: The configuration word is 14 bits wide, laid out as outSel[13:12], delay[11:10], truth table[9:6], shift kind[5:4] and shift amount[3:0]. It is loaded on a rising edge at which cfgWrEn is 1. An operand sampled at that same edge is processed with the old word, and an operand sampled at any later edge is processed with the new word.
- R3: Only the left operand is shifted, by 0 to 15 places. The shift kind codes are: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate left.
- R4: The right operand reaches the truth table unshifted. Bit i of the table result equals truth-table bit (2*s_i + r_i), where s is the shifted left operand and r is the right operand.
- R5: The output select codes are: 0 the truth-table result, 1 the low 16 bits of leftIn+rightIn, 2 the shifted left operand, 3 the truth-table result when the carry-out flag is 1 and 0x0000 otherwise.
- R6: The flags come from the unshifted sum leftIn+rightIn for every output select. flagZero means the low 16 bits are zero, flagNeg is sum bit 15, and flagCarry is the carry out of bit 15.
- R7: An operand pair sampled with inValid=1 at rising edge k appears with outValid=1 right after edge k+delay. That is a latency of delay+1 cycles, and outValid stays 0 in the cycles before it.
- R8: Whenever outValid is 0, outData and all flags are 0. Operands sampled with inValid=0 never produce a valid output.
- R9: Operands applied on consecutive cycles come out on consecutive cycles, in the same order and with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 14 | New configuration word |
| inValid | input | 1 | Operand pair is valid |
| leftIn | input | 16 | Left operand (shiftable) |
| rightIn | input | 16 | Right operand |
| outValid | output | 1 | Result valid |
| outData | output | 16 | Selected result word |
| flagZero | output | 1 | Sum is zero |
| flagNeg | output | 1 | Sum bit 15 |
| flagCarry | output | 1 | Carry out of the sum |

## Verification
A wrong configuration field or shift decode shows up in outData after delay+1 cycles, for the first operand pair sampled after the write. If the configuration is loaded on the wrong edge, a result of the boundary operand pair comes out under the wrong word. If the delay tap points at the wrong stage, outValid rises one or more cycles too early or too late. A gating fault leaves stale data or flags on the outputs during idle cycles, and this is visible on the very next idle cycle.

// File: rtl/mesh_fu_pkg.sv
package mesh_fu_pkg;
  localparam int DATA_W = 16;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int DLY_W = 2;
  localparam int DEPTH = 1 << DLY_W;

  typedef struct packed {
    logic [1:0]         outSel;
    logic [DLY_W-1:0]   dly;
    logic [3:0]         table4;
    logic [1:0]         shKind;
    logic [SHAMT_W-1:0] shAmt;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    cfg_t cfg;
    logic tapValid;
  } ctl_t;

  typedef struct packed {
    logic [DATA_W-1:0] word;
    logic              z;
    logic              n;
    logic              c;
  } res_t;
endpackage

// File: rtl/mesh_fu_ctrl.sv
module mesh_fu_ctrl
  import mesh_fu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             inValid,
  output ctl_t             ctl
);
  cfg_t cfgQ;
  logic [DEPTH-1:0] vldLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfg_t'(cfgWrData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldLine[0] <= 1'b0;
    else vldLine[0] <= inValid;
  end

  for (genvar gi = 1; gi < DEPTH; gi++) begin : gVld
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) vldLine[gi] <= 1'b0;
      else vldLine[gi] <= vldLine[gi-1];
    end
  end

  always_comb begin
    ctl.cfg = cfgQ;
    ctl.tapValid = vldLine[cfgQ.dly];
  end
endmodule

// File: rtl/mesh_fu_datapath.sv
module mesh_fu_datapath
  import mesh_fu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  output logic [DATA_W-1:0] outData,
  output logic              flagZero,
  output logic              flagNeg,
  output logic              flagCarry
);
  logic [DATA_W-1:0]   shifted;
  logic [2*DATA_W-1:0] rotTmp;
  logic [DATA_W-1:0]   tableRes;
  logic [DATA_W:0]     sum;
  res_t                nextRes;
  res_t                pipe [DEPTH];
  res_t                tap;

  always_comb begin
    rotTmp = {leftIn, leftIn} << ctl.cfg.shAmt;
    unique case (ctl.cfg.shKind)
      2'd0: shifted = leftIn << ctl.cfg.shAmt;
      2'd1: shifted = leftIn >> ctl.cfg.shAmt;
      2'd2: shifted = DATA_W'($signed(leftIn) >>> ctl.cfg.shAmt);
      default: shifted = rotTmp[2*DATA_W-1:DATA_W];
    endcase
  end

  for (genvar gb = 0; gb < DATA_W; gb++) begin : gTable
    assign tableRes[gb] = ctl.cfg.table4[{shifted[gb], rightIn[gb]}];
  end

  always_comb begin
    sum = {1'b0, leftIn} + {1'b0, rightIn};
    nextRes.z = (sum[DATA_W-1:0] == '0);
    nextRes.n = sum[DATA_W-1];
    nextRes.c = sum[DATA_W];
    unique case (ctl.cfg.outSel)
      2'd0: nextRes.word = tableRes;
      2'd1: nextRes.word = sum[DATA_W-1:0];
      2'd2: nextRes.word = shifted;
      default: nextRes.word = sum[DATA_W] ? tableRes : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else pipe[0] <= nextRes;
  end

  for (genvar gs = 1; gs < DEPTH; gs++) begin : gDelay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[gs] <= '0;
      else pipe[gs] <= pipe[gs-1];
    end
  end

  always_comb begin
    tap = pipe[ctl.cfg.dly];
    outData   = ctl.tapValid ? tap.word : '0;
    flagZero  = ctl.tapValid & tap.z;
    flagNeg   = ctl.tapValid & tap.n;
    flagCarry = ctl.tapValid & tap.c;
  end
endmodule

// File: rtl/mesh_fu_cell.sv
module mesh_fu_cell
  import mesh_fu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              inValid,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              flagZero,
  output logic              flagNeg,
  output logic              flagCarry
);
  ctl_t ctlBus;

  mesh_fu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .inValid(inValid), .ctl(ctlBus)
  );

  mesh_fu_datapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .leftIn(leftIn), .rightIn(rightIn),
    .outData(outData), .flagZero(flagZero), .flagNeg(flagNeg), .flagCarry(flagCarry)
  );

  assign outValid = ctlBus.tapValid;
endmodule

// File: rtl/mesh_fu_checker.sv
module mesh_fu_checker
  import mesh_fu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [CFG_W-1:0]  cfgWrData,
  input logic              inValid,
  input logic [DATA_W-1:0] leftIn,
  input logic [DATA_W-1:0] rightIn,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              flagZero,
  input logic              flagNeg,
  input logic              flagCarry,
  input cfg_t              cfgQ
);
  logic [2:0] sinceRst;
  logic [DATA_W:0] rawSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assign rawSum = {1'b0, leftIn} + {1'b0, rightIn};

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outData == '0 && !flagZero && !flagNeg && !flagCarry));

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && sinceRst != 3'd0) |=> (cfgQ == cfg_t'($past(cfgWrData))));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && sinceRst != 3'd0) |=> $stable(cfgQ));

  assert_latency0_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd2 && cfgQ.dly == 2'd0) |-> (outValid == $past(inValid)));

  assert_latency3_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd5 && cfgQ.dly == 2'd3) |-> (outValid == $past(inValid, 4)));

  assert_carry_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd1 && cfgQ.dly == 2'd0 && !$past(cfgWrEn) && inValid)
      |=> (flagCarry == $past(rawSum[DATA_W]) && flagZero == ($past(rawSum[DATA_W-1:0]) == '0)));
endmodule

bind mesh_fu_cell mesh_fu_checker uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .inValid(inValid), .leftIn(leftIn), .rightIn(rightIn), .outValid(outValid),
  .outData(outData), .flagZero(flagZero), .flagNeg(flagNeg), .flagCarry(flagCarry),
  .cfgQ(ctlBus.cfg)
);

// File: tb/tb_mesh_fu_cell.sv
module tb_mesh_fu_cell;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [13:0] cfgWrData = '0;
  logic inValid = 1'b0;
  logic [15:0] leftIn = '0;
  logic [15:0] rightIn = '0;
  logic outValid;
  logic [15:0] outData;
  logic flagZero, flagNeg, flagCarry;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mesh_fu_cell dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .inValid(inValid), .leftIn(leftIn), .rightIn(rightIn), .outValid(outValid),
    .outData(outData), .flagZero(flagZero), .flagNeg(flagNeg), .flagCarry(flagCarry)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mkCfg(input int sel, input int dly, input int tbl,
                                        input int kind, input int amt);
    return {sel[1:0], dly[1:0], tbl[3:0], kind[1:0], amt[3:0]};
  endfunction

  function automatic logic [15:0] refShift(input logic [15:0] a, input int kind, input int amt);
    logic [15:0] r;
    r = a;
    for (int s = 0; s < amt; s++) begin
      case (kind)
        0: r = {r[14:0], 1'b0};
        1: r = {1'b0, r[15:1]};
        2: r = {r[15], r[15:1]};
        default: r = {r[14:0], r[15]};
      endcase
    end
    return r;
  endfunction

  function automatic logic [18:0] refResult(input logic [13:0] c, input logic [15:0] a,
                                            input logic [15:0] b);
    logic [15:0] sh, tb, w;
    int sum;
    logic cy;
    sh = refShift(a, int'(c[5:4]), int'(c[3:0]));
    for (int i = 0; i < 16; i++) tb[i] = c[6 + 2*int'(sh[i]) + int'(b[i])];
    sum = int'(a) + int'(b);
    cy = (sum >= 65536);
    case (c[13:12])
      2'd0: w = tb;
      2'd1: w = sum[15:0];
      2'd2: w = sh;
      default: w = cy ? tb : 16'h0;
    endcase
    return {w, (sum[15:0] == 0), sum[15], cy};
  endfunction

  task automatic writeCfg(input logic [13:0] c);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = c;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Sends one pair with config c and checks timing and result.
  task automatic runOne(input string req, input logic [13:0] c, input logic [15:0] a,
                        input logic [15:0] b);
    logic [18:0] e;
    writeCfg(c);
    e = refResult(c, a, b);
    inValid = 1'b1; leftIn = a; rightIn = b;
    @(negedge clk);
    inValid = 1'b0; leftIn = ~a; rightIn = ~b;
    for (int d = 0; d < int'(c[11:10]); d++) begin
      check({req, " R7 early"}, {31'b0, outValid}, 32'd0);
      @(negedge clk);
    end
    check({req, " valid"}, {31'b0, outValid}, 32'd1);
    check(req, {13'b0, outData, flagZero, flagNeg, flagCarry}, {13'b0, e});
    @(negedge clk);
    check({req, " R8 idle"}, {12'b0, outValid, outData, flagZero, flagNeg, flagCarry}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] opsA [4];
    logic [15:0] opsB [4];
    logic [18:0] e;
    opsA = '{16'h8001, 16'h1234, 16'hF0F0, 16'hFFFF};
    opsB = '{16'h7FFF, 16'h4321, 16'h0F0F, 16'h0001};
    repeat (3) @(negedge clk);
    check("R1 reset", {12'b0, outValid, outData, flagZero, flagNeg, flagCarry}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {12'b0, outValid, outData, flagZero, flagNeg, flagCarry}, 32'd0);

    // R3: every shift kind and amount, shifted left operand passed out
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 16; n++)
        runOne("R3 shift", mkCfg(2, 0, 0, k, n), opsA[n % 4], opsB[n % 4]);

    // R4: all truth tables, with and without shift on the left operand
    for (int t = 0; t < 16; t++) begin
      runOne("R4 table", mkCfg(0, 0, t, 0, 0), 16'hF0CC, 16'hAAA5);
      runOne("R4 table shifted", mkCfg(0, 0, t, 3, 5), 16'h1E3C, 16'h5A5A);
    end

    // R5/R6: each output select over operand pairs covering carry, zero, negative
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        runOne("R5 R6 select", mkCfg(s, 0, 4'b0110, 2, 3), opsA[p], opsB[p]);
    runOne("R6 zero flag", mkCfg(1, 0, 0, 0, 0), 16'h0000, 16'h0000);
    runOne("R6 negative", mkCfg(1, 0, 0, 0, 0), 16'h7FFF, 16'h0001);

    // R7: every delay setting
    for (int d = 0; d < 4; d++)
      runOne("R7 delay", mkCfg(1, d, 0, 0, 0), 16'h00F0 + 16'(d), 16'h0101);

    // R2: write and operand on the same edge use the old word; next uses the new
    writeCfg(mkCfg(2, 0, 0, 0, 0));
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = mkCfg(2, 0, 0, 0, 4);
    inValid = 1'b1; leftIn = 16'h0123; rightIn = 16'h0;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check("R2 old word at write edge", {16'b0, outData}, 32'h0123);
    leftIn = 16'h0123;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 new word after write", {16'b0, outData}, 32'h1230);
    @(negedge clk);

    // R8: operands with inValid low never show up, for every delay
    for (int d = 0; d < 4; d++) begin
      writeCfg(mkCfg(1, d, 0, 0, 0));
      for (int j = 0; j < 6; j++) begin
        leftIn = 16'(j * 77 + 1); rightIn = 16'hFFFF;
        @(negedge clk);
        check("R8 ignored input", {12'b0, outValid, outData, flagZero, flagNeg, flagCarry}, 32'd0);
      end
    end

    // R9: back-to-back stream with delay 1 and 2
    for (int d = 1; d < 3; d++) begin
      writeCfg(mkCfg(1, d, 0, 0, 0));
      for (int j = 0; j < 6 + d + 1; j++) begin
        if (j >= d + 1) begin
          e = refResult(mkCfg(1, d, 0, 0, 0), 16'(1000 * (j - d - 1)), 16'hFC00);
          check("R9 stream", {12'b0, outValid, outData, flagZero, flagNeg, flagCarry},
                {12'b0, 1'b1, e});
        end
        if (j < 6) begin
          inValid = 1'b1; leftIn = 16'(1000 * j); rightIn = 16'hFC00;
        end else begin
          inValid = 1'b0;
        end
        @(negedge clk);
      end
      check("R9 stream end", {31'b0, outValid}, 32'd0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule